// File: doc/BRIEF.md
# Three-State Snoopy Line Coherence Controller

This block tracks the coherence state of every line of one private cache in a bus-based multiprocessor. The cache sees two kinds of events: requests from its own processor (read or write of a line) and transactions by other caches that it snoops on the shared bus (a remote read or a remote write of a line). Each line is Invalid, Shared or Dirty. The protocol is write-invalidate. A local write announces itself on the bus so that every other copy of the line drops to Invalid, and a Dirty line that another cache reads is flushed back to memory.

The controller keeps one state per line, addressed by a line index. A small control unit works out the next states and the bus strobes. A state store holds the lines and registers the bus actions. Bus actions appear one clock after the event that causes them, as one-cycle pulses. A combinational lookup port returns the current state of the line that the processor port addresses, so the cache can tell a hit from a miss.

Top module: `snoop_coherence_ctrl`

## Requirements
- R1: After reset every line is Invalid. `cpuLineState` reports the state of line `cpuLine` before the current edge, encoded as 2'b00 Invalid, 2'b01 Shared and 2'b10 Dirty. It never shows 2'b11.
- R2: A local read of an Invalid line moves it to Shared. One cycle later `busRead` pulses with `busLine` equal to that line.
- R3: A local read of a Shared or Dirty line is a hit. The state is unchanged and no bus action follows.
- R4: A local write to an Invalid or Shared line moves it to Dirty. One cycle later `busWrite` (the invalidate) pulses with `busLine` equal to that line.
- R5: A local write to a Dirty line keeps it Dirty and produces no bus action.
- R6: A snooped remote write moves a Shared or Dirty line to Invalid, with no flush. An Invalid line stays Invalid.
- R7: A snooped remote read of a Dirty line moves it to Shared. One cycle later `busFlush` pulses with `flushLine` equal to that line.
- R8: A snooped remote read of a Shared or Invalid line changes nothing and causes no flush.
- R9: When a local event and a snoop event name the same line in the same cycle, the snoop is applied first and the local event acts on the result.
- R10: Local and snoop events on different lines in the same cycle both take effect independently.
- R11: Bus strobes last exactly one cycle per causing event, and `busRead` and `busWrite` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Local processor request present |
| cpuWrite | input | 1 | Local request is a write (0 = read) |
| cpuLine | input | LINE_BITS | Line index of the local request |
| snpValid | input | 1 | Snooped remote transaction present |
| snpWrite | input | 1 | Snooped transaction is a write (0 = read) |
| snpLine | input | LINE_BITS | Line index of the snooped transaction |
| cpuLineState | output | 2 | Current state of line `cpuLine` |
| busRead | output | 1 | Issue a line fetch on the bus |
| busWrite | output | 1 | Issue a write/invalidate on the bus |
| busLine | output | LINE_BITS | Line index for busRead/busWrite |
| busFlush | output | 1 | Write dirty line back to memory |
| flushLine | output | LINE_BITS | Line index for busFlush |

## Verification
The bench builds the block with its default LINE_BITS = 4, which gives 16 lines. At that size the reset state of every line can be read back through the lookup port. The sweep covers every pair of starting states for two lines, every local operation (none, read, write) and every snoop operation (none, read, write), each with the two events on the same line and on different lines. This reaches every transition, every same-cycle ordering case, and the bus strobes together with their line indices.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LINE_INV = 2'b00,
    LINE_SHR = 2'b01,
    LINE_DRT = 2'b10
  } lineState_e;

  typedef struct packed {
    logic       snpWe;
    lineState_e snpNext;
    logic       cpuWe;
    lineState_e cpuNext;
    logic       issueRd;
    logic       issueWr;
    logic       issueFlush;
  } cohStrobe_t;

endpackage

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
(
  input  logic       cpuValid,
  input  logic       cpuWrite,
  input  logic       snpValid,
  input  logic       snpWrite,
  input  logic       sameLine,
  input  lineState_e cpuCur,
  input  lineState_e snpCur,
  output cohStrobe_t strobe
);

  lineState_e cpuBase;

  always_comb begin
    strobe         = '0;
    strobe.snpNext = snpCur;
    // snoop side first
    if (snpValid) begin
      if (snpWrite) begin
        if (snpCur != LINE_INV) begin
          strobe.snpWe   = 1'b1;
          strobe.snpNext = LINE_INV;
        end
      end else if (snpCur == LINE_DRT) begin
        strobe.snpWe      = 1'b1;
        strobe.snpNext    = LINE_SHR;
        strobe.issueFlush = 1'b1;
      end
    end
    // local side sees the post-snoop state when both name one line
    cpuBase        = (snpValid && sameLine) ? strobe.snpNext : cpuCur;
    strobe.cpuNext = cpuBase;
    if (cpuValid) begin
      if (!cpuWrite) begin
        if (cpuBase == LINE_INV) begin
          strobe.cpuWe   = 1'b1;
          strobe.cpuNext = LINE_SHR;
          strobe.issueRd = 1'b1;
        end
      end else if (cpuBase != LINE_DRT) begin
        strobe.cpuWe   = 1'b1;
        strobe.cpuNext = LINE_DRT;
        strobe.issueWr = 1'b1;
      end
    end
  end

endmodule

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int LINE_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LINE_BITS-1:0] cpuIdx,
  input  logic [LINE_BITS-1:0] snpIdx,
  input  cohStrobe_t           strobe,
  output lineState_e           cpuCur,
  output lineState_e           snpCur,
  output logic                 busRdQ,
  output logic                 busWrQ,
  output logic [LINE_BITS-1:0] busIdxQ,
  output logic                 flushQ,
  output logic [LINE_BITS-1:0] flushIdxQ
);

  localparam int NUM_LINES = 1 << LINE_BITS;

  lineState_e stateQ [NUM_LINES];

  assign cpuCur = stateQ[cpuIdx];
  assign snpCur = stateQ[snpIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) stateQ[i] <= LINE_INV;
    end else begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (strobe.cpuWe && (cpuIdx == LINE_BITS'(i)))
          stateQ[i] <= strobe.cpuNext;
        else if (strobe.snpWe && (snpIdx == LINE_BITS'(i)))
          stateQ[i] <= strobe.snpNext;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdQ    <= 1'b0;
      busWrQ    <= 1'b0;
      busIdxQ   <= '0;
      flushQ    <= 1'b0;
      flushIdxQ <= '0;
    end else begin
      busRdQ    <= strobe.issueRd;
      busWrQ    <= strobe.issueWr;
      busIdxQ   <= cpuIdx;
      flushQ    <= strobe.issueFlush;
      flushIdxQ <= snpIdx;
    end
  end

endmodule

// File: rtl/snoop_coherence_ctrl.sv
module snoop_coherence_ctrl
  import coh_pkg::*;
#(
  parameter int LINE_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cpuValid,
  input  logic                 cpuWrite,
  input  logic [LINE_BITS-1:0] cpuLine,
  input  logic                 snpValid,
  input  logic                 snpWrite,
  input  logic [LINE_BITS-1:0] snpLine,
  output logic [1:0]           cpuLineState,
  output logic                 busRead,
  output logic                 busWrite,
  output logic [LINE_BITS-1:0] busLine,
  output logic                 busFlush,
  output logic [LINE_BITS-1:0] flushLine
);

  cohStrobe_t strobe;
  lineState_e cpuCur;
  lineState_e snpCur;

  coh_ctrl u_ctrl (
    .cpuValid (cpuValid),
    .cpuWrite (cpuWrite),
    .snpValid (snpValid),
    .snpWrite (snpWrite),
    .sameLine (cpuLine == snpLine),
    .cpuCur   (cpuCur),
    .snpCur   (snpCur),
    .strobe   (strobe)
  );

  coh_line_store #(.LINE_BITS(LINE_BITS)) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .cpuIdx    (cpuLine),
    .snpIdx    (snpLine),
    .strobe    (strobe),
    .cpuCur    (cpuCur),
    .snpCur    (snpCur),
    .busRdQ    (busRead),
    .busWrQ    (busWrite),
    .busIdxQ   (busLine),
    .flushQ    (busFlush),
    .flushIdxQ (flushLine)
  );

  assign cpuLineState = cpuCur;

endmodule

// File: rtl/coh_checker.sv
module coh_checker #(
  parameter int LINE_BITS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cpuValid,
  input logic                 cpuWrite,
  input logic [LINE_BITS-1:0] cpuLine,
  input logic                 snpValid,
  input logic                 snpWrite,
  input logic [LINE_BITS-1:0] snpLine,
  input logic [1:0]           cpuLineState,
  input logic                 busRead,
  input logic                 busWrite,
  input logic [LINE_BITS-1:0] busLine,
  input logic                 busFlush,
  input logic [LINE_BITS-1:0] flushLine
);

  logic sameLine;
  assign sameLine = snpValid && (snpLine == cpuLine);

  assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rstN)
    cpuLineState != 2'b11);

  assert_fetch_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    busRead |-> $past(cpuValid && !cpuWrite));

  assert_read_hit_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && !cpuWrite && cpuLineState != 2'b00 && !(sameLine && snpWrite)) |=> !busRead);

  assert_inval_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    busWrite |-> $past(cpuValid && cpuWrite));

  assert_bus_index_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busRead || busWrite) |-> busLine == $past(cpuLine));

  assert_dirty_write_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && cpuWrite && cpuLineState == 2'b10 && !sameLine) |=> !busWrite);

  assert_flush_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    busFlush |-> $past(snpValid && !snpWrite));

  assert_flush_index_R7: assert property (@(posedge clk) disable iff (!rstN)
    busFlush |-> flushLine == $past(snpLine));

  assert_bus_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(busRead && busWrite));

endmodule

bind snoop_coherence_ctrl coh_checker #(.LINE_BITS(LINE_BITS)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cpuValid     (cpuValid),
  .cpuWrite     (cpuWrite),
  .cpuLine      (cpuLine),
  .snpValid     (snpValid),
  .snpWrite     (snpWrite),
  .snpLine      (snpLine),
  .cpuLineState (cpuLineState),
  .busRead      (busRead),
  .busWrite     (busWrite),
  .busLine      (busLine),
  .busFlush     (busFlush),
  .flushLine    (flushLine)
);

// File: tb/tb_snoop_coherence_ctrl.sv
module tb_snoop_coherence_ctrl;

  localparam int LB = 4;
  localparam int NL = 1 << LB;
  localparam logic [1:0] S_INV = 2'b00, S_SHR = 2'b01, S_DRT = 2'b10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuValid = 1'b0, cpuWrite = 1'b0, snpValid = 1'b0, snpWrite = 1'b0;
  logic [LB-1:0] cpuLine = '0, snpLine = '0;
  logic [1:0] cpuLineState;
  logic busRead, busWrite, busFlush;
  logic [LB-1:0] busLine, flushLine;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  logic [1:0] model [NL];

  always #10 clk = ~clk;

  snoop_coherence_ctrl #(.LINE_BITS(LB)) dut (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuLine(cpuLine),
    .snpValid(snpValid), .snpWrite(snpWrite), .snpLine(snpLine),
    .cpuLineState(cpuLineState),
    .busRead(busRead), .busWrite(busWrite), .busLine(busLine),
    .busFlush(busFlush), .flushLine(flushLine)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doOp(logic cV, logic cW, logic [LB-1:0] cA,
                      logic sV, logic sW, logic [LB-1:0] sA);
    logic [1:0] st, sst;
    logic eRd, eWr, eFl;
    string tag;
    eRd = 0; eWr = 0; eFl = 0;
    @(negedge clk);
    cpuValid = cV; cpuWrite = cW; cpuLine = cA;
    snpValid = sV; snpWrite = sW; snpLine = sA;
    #1;
    sst = model[sA];
    st  = model[cA];
    if (cV && sV) tag = (cA == sA) ? "R9" : "R10";
    else if (cV) tag = cW ? ((st == S_DRT) ? "R5" : "R4") : ((st == S_INV) ? "R2" : "R3");
    else if (sV) tag = sW ? "R6" : ((sst == S_DRT) ? "R7" : "R8");
    else tag = "R11";
    check({tag, " lookup"}, {6'b0, cpuLineState}, {6'b0, st});
    // model: snoop first, then local
    if (sV) begin
      if (sW) model[sA] = S_INV;
      else if (model[sA] == S_DRT) begin model[sA] = S_SHR; eFl = 1; end
    end
    if (cV) begin
      if (!cW) begin
        if (model[cA] == S_INV) begin model[cA] = S_SHR; eRd = 1; end
      end else if (model[cA] != S_DRT) begin
        model[cA] = S_DRT; eWr = 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " busRead"}, {7'b0, busRead}, {7'b0, eRd});
    check({tag, " busWrite"}, {7'b0, busWrite}, {7'b0, eWr});
    check({tag, " busFlush"}, {7'b0, busFlush}, {7'b0, eFl});
    if (eRd || eWr) check({tag, " busLine"}, {4'b0, busLine}, {4'b0, cA});
    if (eFl) check({tag, " flushLine"}, {4'b0, flushLine}, {4'b0, sA});
    cpuValid = 0; snpValid = 0;
    @(negedge clk);
    check("R11 pulse ends", {6'b0, busRead, busWrite}, 8'h0);
    check("R11 flush ends", {7'b0, busFlush}, 8'h0);
  endtask

  task automatic setLine(logic [LB-1:0] idx, logic [1:0] s);
    doOp(0, 0, idx, 1, 1, idx);
    if (s == S_SHR) doOp(1, 0, idx, 0, 0, idx);
    if (s == S_DRT) doOp(1, 1, idx, 0, 0, idx);
  endtask

  initial begin
    for (int i = 0; i < NL; i++) model[i] = S_INV;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: every line Invalid after reset
    for (int i = 0; i < NL; i++) begin
      cpuLine = LB'(i);
      #1;
      check("R1 reset state", {6'b0, cpuLineState}, {6'b0, S_INV});
      @(negedge clk);
    end
    check("R1 no strobes after reset", {5'b0, busRead, busWrite, busFlush}, 8'h0);
    begin
      int k = 0;
      for (int sa = 0; sa < 3; sa++)
        for (int sb = 0; sb < 3; sb++)
          for (int cop = 0; cop < 3; cop++)
            for (int sop = 0; sop < 3; sop++)
              for (int same = 0; same < 2; same++) begin
                logic [LB-1:0] a, b, sl;
                a = LB'((k * 5) % NL);
                b = LB'((int'(a) + 1 + (k % (NL - 1))) % NL);
                setLine(a, 2'(sa));
                setLine(b, 2'(sb));
                sl = same ? a : b;
                doOp(cop != 0, cop == 2, a, sop != 0, sop == 2, sl);
                // read back resulting states through lookup
                doOp(0, 0, a, 0, 0, a);
                doOp(0, 0, b, 0, 0, b);
                k++;
              end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule